// File: doc/BRIEF.md
# Strided Debug Memory Readback Port

This block gives a register bus a way to read internal debug state that lives in small memories rather than in flops. The bus address does not select a memory entry. A separate index register, programmed by software, holds a 16-bit read pointer and a 16-bit stride. A read of any memory-backed address returns the entry that the pointer selects, and the pointer then moves forward by the stride. Programming pointer 0 and stride 1 lets software drain a whole memory with back-to-back reads of a single address.

Three memories, each 64 bits wide, sit behind the port. Memory 0 holds 32 entries; memories 1 and 2 hold 256 entries each. Each has its own write enable, driven by the datapath that owns the debug state; address and data of that fill port are shared. The bus is a single-cycle request with an acknowledge one cycle later. A small controller, with states ST_IDLE (no response due) and ST_RESP (a response is on the bus this cycle), tracks the response. Every cycle with a request moves it to ST_RESP; every cycle without one moves it to ST_IDLE, from either state. It also records what kind of data the response carries.

Bus address map: 0 is the index register (pointer in bits [15:0], stride in bits [31:16]); 1, 2 and 3 read memories 0, 1 and 2; all other addresses are unmapped.

Top module: `dbg_idx_readback`

## Requirements
- R1: While reset is held and right after it, the acknowledge is low and the index register reads as zero (pointer 0, stride 0).
- R2: A write to address 0 loads the pointer from write-data bits [15:0] and the stride from bits [31:16]; reading address 0 returns them in the same positions with bits [63:32] zero, whatever was written there.
- R3: A read of address 1, 2 or 3 returns the entry of memory 0, 1 or 2 that the current pointer selects, as last written through that memory's fill port.
- R4: Each read of addresses 1 to 3 replaces the pointer with pointer plus stride; reading address 0 leaves the pointer unchanged.
- R5: With pointer 0 and stride 1, consecutive reads of one memory address return its entries 0, 1, 2 and so on through the last entry.
- R6: Only the low log2(depth) pointer bits address a memory, so a pointer past its depth reads an aliased lower entry (pointer 40 reads entry 8 of the 32-entry memory).
- R7: The pointer sum wraps modulo 2^16 (pointer 0xFFFE plus stride 3 gives 0x0001).
- R8: Every request, read or write, is acknowledged exactly one cycle later, with the read data valid in that same cycle; requests may come in consecutive cycles.
- R9: Writes to addresses 1 to 7 and reads of addresses 4 to 7 change neither pointer, stride nor memory contents; their acknowledge, and that of every write, carries zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request strobe, one cycle per request |
| req_write | input | 1 | 1 for a write request, 0 for a read |
| req_addr | input | ADDR_W (3) | Bus register address |
| req_wdata | input | DATA_W (64) | Bus write data |
| rsp_ack | output | 1 | Acknowledge, one cycle after each request |
| rsp_rdata | output | DATA_W (64) | Read data, valid with the acknowledge, zero otherwise |
| fill_en | input | NUM_MEM (3) | Per-memory write enable from the datapath |
| fill_addr | input | FILL_AW (8) | Fill write address, low bits used per memory |
| fill_data | input | DATA_W (64) | Fill write data |

## Verification
The properties take it that the pointer and stride move only through a bus request. They also take it that the bus issues at most one request per cycle and does not drop a request. The contents of an entry are assumed to be defined only after that entry has been filled. The stimulus fills every entry of all three memories through the fill ports before any memory read. It drives one request per cycle from a single task. The reference model tracks the pointer itself, so no read ever selects an unfilled entry and no check depends on undefined contents.

// File: rtl/dbgrb_pkg.sv
package dbgrb_pkg;

    // Response controller states
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } ctl_state_e;

    // What the pending response carries
    typedef enum logic [1:0] {
        RK_ZERO  = 2'd0,
        RK_INDEX = 2'd1,
        RK_MEM   = 2'd2
    } rsp_kind_e;

    localparam int unsigned ADDR_INDEX    = 0;
    localparam int unsigned ADDR_MEM_BASE = 1;

endpackage

// File: rtl/dbgrb_index.sv
module dbgrb_index #(
    parameter int unsigned IDX_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [2*IDX_W-1:0] load_val,
    input  logic               step,
    output logic [IDX_W-1:0]   idx,
    output logic [IDX_W-1:0]   inc
);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] inc_q;

    // A load always wins over a step; the sum wraps at the pointer width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            inc_q <= '0;
        end else if (load) begin
            idx_q <= load_val[IDX_W-1:0];
            inc_q <= load_val[2*IDX_W-1:IDX_W];
        end else if (step) begin
            idx_q <= idx_q + inc_q;
        end
    end

    assign idx = idx_q;
    assign inc = inc_q;

    // R9
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> ($stable(idx) && $stable(inc)));

    // R2
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (idx == $past(load_val[IDX_W-1:0]) && inc == $past(load_val[2*IDX_W-1:IDX_W])));

endmodule

// File: rtl/dbgrb_mem.sv
module dbgrb_mem #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] store [DEPTH];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_q <= store[rd_addr];
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/dbgrb_ctrl.sv
module dbgrb_ctrl
    import dbgrb_pkg::*;
#(
    parameter int unsigned ADDR_W  = 3,
    parameter int unsigned NUM_MEM = 3,
    parameter int unsigned SEL_W   = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    output logic               rsp_ack,
    output rsp_kind_e          rsp_kind,
    output logic [SEL_W-1:0]   rsp_sel,
    output logic               idx_load,
    output logic               idx_step,
    output logic [NUM_MEM-1:0] mem_rd_en
);

    ctl_state_e       state_q, state_d;
    rsp_kind_e        kind_q, kind_d;
    logic [SEL_W-1:0] sel_q, sel_d;

    logic             hit_index;
    logic             hit_mem;
    logic [SEL_W-1:0] mem_num;

    // Address decode
    always_comb begin
        hit_index = req_valid && (int'(req_addr) == ADDR_INDEX);
        hit_mem   = req_valid && (int'(req_addr) >= ADDR_MEM_BASE)
                              && (int'(req_addr) < ADDR_MEM_BASE + NUM_MEM);
        mem_num   = SEL_W'(int'(req_addr) - ADDR_MEM_BASE);
    end

    assign idx_load = hit_index && req_write;
    assign idx_step = hit_mem && !req_write;

    for (genvar g = 0; g < NUM_MEM; g++) begin : g_rd_en
        assign mem_rd_en[g] = idx_step && (mem_num == SEL_W'(g));
    end

    // Next-state and response-kind decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase

        kind_d = RK_ZERO;
        sel_d  = '0;
        if (req_valid && !req_write) begin
            if (hit_index) begin
                kind_d = RK_INDEX;
            end else if (hit_mem) begin
                kind_d = RK_MEM;
                sel_d  = mem_num;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= RK_ZERO;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            sel_q   <= sel_d;
        end
    end

    // Outputs
    always_comb begin
        rsp_ack  = 1'b0;
        rsp_kind = RK_ZERO;
        rsp_sel  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESP: begin
                rsp_ack  = 1'b1;
                rsp_kind = kind_q;
                rsp_sel  = sel_q;
            end
            default: ;
        endcase
    end

    // R8
    ack_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_ack);

    // R8
    no_spurious_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_ack);

endmodule

// File: rtl/dbg_idx_readback.sv
module dbg_idx_readback
    import dbgrb_pkg::*;
#(
    parameter int unsigned ADDR_W  = 3,
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned IDX_W   = 16,
    parameter int unsigned NUM_MEM = 3,
    parameter int unsigned DEPTH0  = 32,
    parameter int unsigned DEPTH1  = 256,
    parameter int unsigned DEPTH2  = 256,
    parameter int unsigned FILL_AW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_ack,
    output logic [DATA_W-1:0]  rsp_rdata,
    input  logic [NUM_MEM-1:0] fill_en,
    input  logic [FILL_AW-1:0] fill_addr,
    input  logic [DATA_W-1:0]  fill_data
);

    localparam int unsigned SEL_W = (NUM_MEM > 1) ? $clog2(NUM_MEM) : 1;

    rsp_kind_e          rsp_kind;
    logic [SEL_W-1:0]   rsp_sel;
    logic               idx_load;
    logic               idx_step;
    logic [NUM_MEM-1:0] mem_rd_en;
    logic [IDX_W-1:0]   cur_idx;
    logic [IDX_W-1:0]   cur_inc;
    logic [DATA_W-1:0]  mem_rdata [NUM_MEM];

    dbgrb_ctrl #(
        .ADDR_W  (ADDR_W),
        .NUM_MEM (NUM_MEM),
        .SEL_W   (SEL_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .rsp_ack   (rsp_ack),
        .rsp_kind  (rsp_kind),
        .rsp_sel   (rsp_sel),
        .idx_load  (idx_load),
        .idx_step  (idx_step),
        .mem_rd_en (mem_rd_en)
    );

    dbgrb_index #(
        .IDX_W (IDX_W)
    ) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (idx_load),
        .load_val (req_wdata[2*IDX_W-1:0]),
        .step     (idx_step),
        .idx      (cur_idx),
        .inc      (cur_inc)
    );

    for (genvar g = 0; g < NUM_MEM; g++) begin : g_mem
        localparam int unsigned D  = (g == 0) ? DEPTH0 : ((g == 1) ? DEPTH1 : DEPTH2);
        localparam int unsigned AW = (D > 1) ? $clog2(D) : 1;

        dbgrb_mem #(
            .DEPTH  (D),
            .DATA_W (DATA_W),
            .AW     (AW)
        ) u_mem (
            .clk     (clk),
            .wr_en   (fill_en[g]),
            .wr_addr (fill_addr[AW-1:0]),
            .wr_data (fill_data),
            .rd_en   (mem_rd_en[g]),
            .rd_addr (cur_idx[AW-1:0]),
            .rd_data (mem_rdata[g])
        );
    end

    // Response data steering
    always_comb begin
        rsp_rdata = '0;
        unique case (rsp_kind)
            RK_INDEX: rsp_rdata = DATA_W'({cur_inc, cur_idx});
            RK_MEM: begin
                if (int'(rsp_sel) < NUM_MEM) begin
                    rsp_rdata = mem_rdata[rsp_sel];
                end
            end
            default: rsp_rdata = '0;
        endcase
    end

    // R9
    write_ack_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == '0));

    // R2
    index_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && int'(req_addr) == ADDR_INDEX)
            |=> (rsp_rdata[DATA_W-1:2*IDX_W] == '0));

    // R9
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && int'(req_addr) >= ADDR_MEM_BASE + NUM_MEM)
            |=> (rsp_rdata == '0));

endmodule

// File: tb/dbg_idx_readback_tb.sv
module dbg_idx_readback_tb;

    localparam real CLK_NS = 4.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_ack;
    logic [63:0] rsp_rdata;
    logic [2:0]  fill_en = '0;
    logic [7:0]  fill_addr = '0;
    logic [63:0] fill_data = '0;

    always #(CLK_NS / 2.0) clk = ~clk;

    dbg_idx_readback u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_ack   (rsp_ack),
        .rsp_rdata (rsp_rdata),
        .fill_en   (fill_en),
        .fill_addr (fill_addr),
        .fill_data (fill_data)
    );

    typedef struct {
        logic [63:0] data;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_tests = 0;
    int          n_fail  = 0;
    logic        req_seen = 1'b0;
    bit          done = 1'b0;

    logic [63:0] ref0 [32];
    logic [63:0] ref1 [256];
    logic [63:0] ref2 [256];
    logic [15:0] m_idx = '0;
    logic [15:0] m_inc = '0;

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] pattern(int k, int i);
        return {8'(k + 1), 8'(i), 16'(i * 7 + k * 91), 32'(i * 32'h01010101) ^ 32'hA5A5_0000};
    endfunction

    function automatic logic [63:0] ref_read(int k, logic [15:0] p);
        case (k)
            0:       return ref0[p[4:0]];
            1:       return ref1[p[7:0]];
            default: return ref2[p[7:0]];
        endcase
    endfunction

    // Monitor: request seen at an edge must be acknowledged by the next one
    always @(posedge clk) req_seen <= rst_n && req_valid;

    always @(negedge clk) begin
        if (rst_n) begin
            if (req_seen || rsp_ack) begin
                check(rsp_ack == req_seen, "R8", 64'(rsp_ack), 64'(req_seen));
            end
            if (rsp_ack) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R8", 64'(rsp_ack), 64'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(rsp_rdata === e.data, e.tag, rsp_rdata, e.data);
                end
            end
        end
    end

    // Driver tasks: called at a falling edge, return at the next one
    task automatic issue(bit wr, logic [2:0] a, logic [63:0] wd, logic [63:0] exp, string tag);
        exp_t e;
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        e.data = exp;
        e.tag  = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        req_valid = 1'b0;
        req_write = 1'b0;
        for (int c = 0; c < n; c++) @(negedge clk);
    endtask

    task automatic wr_index(logic [15:0] p, logic [15:0] s, logic [31:0] upper);
        issue(1'b1, 3'd0, {upper, s, p}, 64'd0, "R2");
        m_idx = p;
        m_inc = s;
    endtask

    task automatic rd_index(string tag);
        issue(1'b0, 3'd0, 64'd0, {32'd0, m_inc, m_idx}, tag);
    endtask

    task automatic rd_mem(int k, string tag);
        logic [63:0] exp;
        exp = ref_read(k, m_idx);
        m_idx = m_idx + m_inc;
        issue(1'b0, 3'(k + 1), 64'd0, exp, tag);
    endtask

    task automatic fill(int k, int i, logic [63:0] d);
        fill_en   = 3'(1 << k);
        fill_addr = 8'(i);
        fill_data = d;
        case (k)
            0:       ref0[i[4:0]] = d;
            1:       ref1[i[7:0]] = d;
            default: ref2[i[7:0]] = d;
        endcase
        @(negedge clk);
        fill_en = '0;
    endtask

    // Watchdog
    initial begin
        #(CLK_NS * 150000.0);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(rsp_ack == 1'b0, "R1", 64'(rsp_ack), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_ack == 1'b0, "R1", 64'(rsp_ack), 64'd0);
        rd_index("R1");
        idle(1);

        // Fill every entry of every memory (R3)
        for (int i = 0; i < 32; i++)  fill(0, i, pattern(0, i));
        for (int i = 0; i < 256; i++) fill(1, i, pattern(1, i));
        for (int i = 0; i < 256; i++) fill(2, i, pattern(2, i));
        idle(1);

        // R2: upper write bits are dropped on readback
        wr_index(16'h0000, 16'h0001, 32'hDEAD_BEEF);
        rd_index("R2");
        idle(1);

        // R5: walk the 32-entry memory back to back, then R4 pointer check
        for (int i = 0; i < 32; i++) rd_mem(0, "R5");
        rd_index("R4");
        rd_index("R4");
        idle(2);

        // R5: walk a 256-entry memory
        wr_index(16'h0000, 16'h0001, 32'd0);
        for (int i = 0; i < 256; i++) rd_mem(1, "R5");
        idle(1);

        // R3 / R4: stride 3 from pointer 5 on memory 2, with gaps
        wr_index(16'd5, 16'd3, 32'd0);
        rd_mem(2, "R3");
        idle(1);
        rd_mem(2, "R3");
        rd_index("R4");
        rd_mem(2, "R3");
        rd_index("R4");
        idle(2);

        // R6: aliasing past depth
        wr_index(16'd40, 16'd0, 32'd0);
        rd_mem(0, "R6");
        rd_mem(0, "R6");
        wr_index(16'h0123, 16'h0100, 32'd0);
        rd_mem(1, "R6");
        rd_mem(2, "R6");
        rd_index("R6");
        idle(1);

        // R7: wrap modulo 2^16
        wr_index(16'hFFFE, 16'd3, 32'd0);
        rd_mem(1, "R7");
        rd_index("R7");
        rd_mem(2, "R7");
        rd_index("R7");
        idle(1);

        // R9: ignored writes and unmapped reads
        wr_index(16'd9, 16'd2, 32'd0);
        issue(1'b1, 3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, "R9");
        issue(1'b1, 3'd2, 64'h1234_5678_9ABC_DEF0, 64'd0, "R9");
        issue(1'b1, 3'd5, 64'h0000_0007_0000_0007, 64'd0, "R9");
        issue(1'b0, 3'd4, 64'd0, 64'd0, "R9");
        issue(1'b0, 3'd7, 64'd0, 64'd0, "R9");
        rd_index("R9");
        rd_mem(0, "R9");
        rd_mem(1, "R9");
        rd_index("R9");
        idle(3);

        check(sb.size() == 0, "R8", 64'(sb.size()), 64'd0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule